// File: doc/BRIEF.md
# SDRAM Self-Refresh Sequencer

This block takes an SDRAM controller's command and clock-enable lines into self-refresh and back out again when a low-power request arrives. When the requester raises `sleep_req`, the block closes every bank with a precharge-all command. It waits the row-precharge time and then issues the refresh command in the same cycle that it drives `cke` low. It acknowledges with `sleep_ack` in that entry cycle.

The device then stays in self-refresh for at least the minimum residency, however early the wake request comes. Dropping `sleep_req` asks for wake-up. CKE rises only after `clk_stable` has been seen high. NOP commands follow for the exit-recovery window before the acknowledge is withdrawn and the controller may resume normal traffic. All timings are parameters in clock cycles: `T_RP`, `T_RAS` and `T_XSR`, where `T_RP` and `T_RAS` must be at least 2.

The states are IDLE, PRECHARGE, WAIT_RP, ENTER, RESIDE, WAIT_CLK, EXIT_NOP and DONE. The transitions are:
- IDLE→PRECHARGE on request.
- PRECHARGE→WAIT_RP unconditionally.
- WAIT_RP→ENTER when the precharge timer expires.
- ENTER→RESIDE unconditionally.
- RESIDE→EXIT_NOP when residency has elapsed, the request is low and the clock is stable.
- RESIDE→WAIT_CLK when residency has elapsed and the request is low but the clock is not yet stable.
- WAIT_CLK→EXIT_NOP when the clock is stable.
- EXIT_NOP→DONE when the recovery timer expires.
- DONE→IDLE unconditionally.

Top module: `sref_sequencer`

## Requirements
- R1: An active-low asynchronous reset immediately forces `cke`=1, `cmd`=NOP (4'b0111), `pre_all`=0 and `sleep_ack`=0, including in the middle of self-refresh.
- R2: In IDLE the command is NOP (4'b0111, bits {cs_n,ras_n,cas_n,we_n}). The cycle after `sleep_req` is sampled high there, `cmd` is precharge (4'b0010), `pre_all`=1 and `cke`=1.
- R3: The refresh command (4'b0001) with `cke`=0 appears exactly `T_RP` cycles after the precharge cycle. Every cycle in between carries NOP with `cke`=1.
- R4: `sleep_ack` rises in the entry cycle, together with the refresh command and low `cke`, and stays high while `cke` is low.
- R5: Count the entry cycle as 0. Let w be the first cycle in which `sleep_req` is sampled low and s the first cycle in which `clk_stable` is sampled high. Then `cke` returns high in cycle max(`T_RAS`-1, w, s)+1, so it is low for at least `T_RAS` cycles and an early wake is deferred.
- R6: Every cycle after the entry cycle in which `cke` is low carries NOP.
- R7: `cke` rises only in the cycle after `clk_stable` is sampled high. While `clk_stable` stays low, `cke` stays low.
- R8: After `cke` rises, exactly max(`T_XSR`,2) cycles follow with `cke`=1, NOP and `sleep_ack`=1. In the next cycle (DONE) `sleep_ack` is low.
- R9: While `sleep_req` stays high the block remains in self-refresh indefinitely.
- R10: The cycle after `sleep_ack` falls the block is idle (NOP, `cke`=1). A request held from the cycle of the fall produces precharge two cycles after the fall.
- R11: Dropping `sleep_req` during PRECHARGE or WAIT_RP does not abort entry. Refresh entry still occurs and the minimum residency is still kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | High requests self-refresh; low requests wake |
| clk_stable | input | 1 | High when the memory clock is within its timing limits |
| sleep_ack | output | 1 | High from entry until the exit-recovery window ends |
| cke | output | 1 | Clock enable to the SDRAM |
| cmd | output | 4 | Command {cs_n,ras_n,cas_n,we_n} |
| pre_all | output | 1 | Address bit selecting all banks for precharge |

## Verification
The bench sweeps the wake cycle and the clock-stable cycle independently across and beyond the residency window. It compares the CKE rise cycle with the max() formula of R5. A design that let an early wake through would shorten residency. One that raised CKE without waiting for the clock, or one that lost a wake request that arrived while the clock was unstable, would miss the expected cycle. Entry is also checked with the request withdrawn during precharge, which a design that aborted would skip. Further checks cover a long hold, the exact precharge-to-refresh gap, the recovery NOP count and acknowledge fall, the immediate re-request after DONE, and a reset issued while CKE is low.

// File: rtl/sref_pkg.sv
package sref_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECHARGE,
        ST_WAIT_RP,
        ST_ENTER,
        ST_RESIDE,
        ST_WAIT_CLK,
        ST_EXIT_NOP,
        ST_DONE
    } sref_state_e;

    // command bits {cs_n, ras_n, cas_n, we_n}
    typedef logic [3:0] sdr_cmd_t;

    localparam sdr_cmd_t CMD_NOP = 4'b0111;
    localparam sdr_cmd_t CMD_PRE = 4'b0010;
    localparam sdr_cmd_t CMD_REF = 4'b0001;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sref_timer.sv
module sref_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sref_out_decode.sv
module sref_out_decode
    import sref_pkg::*;
(
    input  sref_state_e state,
    output logic        cke,
    output sdr_cmd_t    cmd,
    output logic        pre_all,
    output logic        ack
);

    always_comb begin
        cke     = 1'b1;
        cmd     = CMD_NOP;
        pre_all = 1'b0;
        ack     = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_PRECHARGE: begin
                cmd     = CMD_PRE;
                pre_all = 1'b1;
            end
            ST_WAIT_RP: begin
            end
            ST_ENTER: begin
                cmd = CMD_REF;
                cke = 1'b0;
                ack = 1'b1;
            end
            ST_RESIDE, ST_WAIT_CLK: begin
                cke = 1'b0;
                ack = 1'b1;
            end
            ST_EXIT_NOP: begin
                ack = 1'b1;
            end
            ST_DONE: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/sref_sequencer.sv
module sref_sequencer
    import sref_pkg::*;
#(
    parameter int unsigned T_RP  = 3,
    parameter int unsigned T_RAS = 6,
    parameter int unsigned T_XSR = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       clk_stable,
    output logic       sleep_ack,
    output logic       cke,
    output logic [3:0] cmd,
    output logic       pre_all
);

    localparam int unsigned NX   = umax(T_XSR, 2);
    localparam int unsigned MAXV = umax(umax(T_RP, T_RAS), NX);
    localparam int unsigned CW   = $clog2(MAXV + 1);

    localparam logic [CW-1:0] RP_LOAD  = CW'(T_RP - 2);
    localparam logic [CW-1:0] RAS_LOAD = CW'(T_RAS - 2);
    localparam logic [CW-1:0] XSR_LOAD = CW'(NX - 1);

    sref_state_e   state_q, state_d;
    logic          tm_load;
    logic [CW-1:0] tm_val;
    logic          tm_expired;
    sdr_cmd_t      cmd_w;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and timer loads
    always_comb begin
        state_d = state_q;
        tm_load = 1'b0;
        tm_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (sleep_req) state_d = ST_PRECHARGE;
            end
            ST_PRECHARGE: begin
                state_d = ST_WAIT_RP;
                tm_load = 1'b1;
                tm_val  = RP_LOAD;
            end
            ST_WAIT_RP: begin
                if (tm_expired) state_d = ST_ENTER;
            end
            ST_ENTER: begin
                state_d = ST_RESIDE;
                tm_load = 1'b1;
                tm_val  = RAS_LOAD;
            end
            ST_RESIDE: begin
                if (tm_expired && !sleep_req) begin
                    if (clk_stable) begin
                        state_d = ST_EXIT_NOP;
                        tm_load = 1'b1;
                        tm_val  = XSR_LOAD;
                    end else begin
                        state_d = ST_WAIT_CLK;
                    end
                end
            end
            ST_WAIT_CLK: begin
                if (clk_stable) begin
                    state_d = ST_EXIT_NOP;
                    tm_load = 1'b1;
                    tm_val  = XSR_LOAD;
                end
            end
            ST_EXIT_NOP: begin
                if (tm_expired) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    sref_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_val (tm_val),
        .expired  (tm_expired)
    );

    // outputs decoded from the state register
    sref_out_decode u_dec (
        .state   (state_q),
        .cke     (cke),
        .cmd     (cmd_w),
        .pre_all (pre_all),
        .ack     (sleep_ack)
    );

    assign cmd = cmd_w;

    // ---------------- assertion support counters ----------------
    logic [15:0] low_run, hi_run, since_pre;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run   <= '0;
            hi_run    <= '0;
            since_pre <= '0;
        end else begin
            if (cke) low_run <= '0;
            else if (low_run != 16'hFFFF) low_run <= low_run + 16'd1;

            if (!(cke && sleep_ack)) hi_run <= '0;
            else if (hi_run != 16'hFFFF) hi_run <= hi_run + 16'd1;

            if (cmd == CMD_PRE) since_pre <= 16'd1;
            else if (since_pre != 16'hFFFF && since_pre != 16'd0) since_pre <= since_pre + 16'd1;
        end
    end

    assert_pre_after_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> ($past(sleep_req) && cke));

    assert_ref_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |-> (since_pre == 16'(T_RP) && !cke));

    assert_ack_on_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_ack) |-> (cmd == CMD_REF && !cke));

    assert_min_residency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (low_run >= 16'(T_RAS)));

    assert_nop_while_asleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && $past(!cke)) |-> (cmd == CMD_NOP));

    assert_cke_rise_clock_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> $past(clk_stable));

    assert_exit_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_ack) |-> (hi_run == 16'(NX) && cke && cmd == CMD_NOP));

endmodule

// File: tb/sref_sequencer_test.sv
module sref_sequencer_test;

    localparam int PERIOD = 10;
    localparam int TRP  = 3;
    localparam int TRAS = 5;
    localparam int TXSR = 4;
    localparam int NXE  = (TXSR > 2) ? TXSR : 2;

    localparam logic [3:0] NOP_C = 4'b0111;
    localparam logic [3:0] PRE_C = 4'b0010;
    localparam logic [3:0] REF_C = 4'b0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0;
    logic clk_stable = 1'b0;
    logic sleep_ack, cke, pre_all;
    logic [3:0] cmd;

    int n_chk = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    sref_sequencer #(.T_RP(TRP), .T_RAS(TRAS), .T_XSR(TXSR)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .clk_stable (clk_stable),
        .sleep_ack  (sleep_ack),
        .cke        (cke),
        .cmd        (cmd),
        .pre_all    (pre_all)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int imax3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // one full entry/residency/exit pass; called and returning at a negedge
    task automatic sleep_pass(input int w, input int s, input bit early, input bit rearm);
        int got;
        int exp_hi;
        got = -1;
        exp_hi = imax3(TRAS - 1, early ? 0 : w, s) + 1;
        chk(cke && cmd == NOP_C && !sleep_ack, "R2 idle NOP", cmd, NOP_C);
        clk_stable = 1'b0;
        sleep_req  = 1'b1;
        @(negedge clk);
        chk(cmd == PRE_C && pre_all && cke, "R2 precharge", cmd, PRE_C);
        if (early) sleep_req = 1'b0;  // R11 withdraw during precharge
        for (int k = 1; k < TRP; k++) begin
            @(negedge clk);
            chk(cmd == NOP_C && cke, "R3 gap NOP", cmd, NOP_C);
        end
        @(negedge clk);
        chk(cmd == REF_C && !cke, "R3 refresh entry (R11)", cmd, REF_C);
        chk(sleep_ack, "R4 ack at entry", sleep_ack, 1);
        for (int i = 0; i < 400; i++) begin
            if (i > 0) @(negedge clk);
            if (cke) begin
                got = i;
                break;
            end
            if (i > 0) begin
                chk(cmd == NOP_C, "R6 NOP while low", cmd, NOP_C);
                chk(sleep_ack, "R4 ack held", sleep_ack, 1);
            end
            if (!early && i == w) sleep_req = 1'b0;
            if (i == s) clk_stable = 1'b1;
        end
        chk(got == exp_hi, "R5 R7 cke rise cycle", got, exp_hi);
        chk(clk_stable, "R7 clock stable at rise", clk_stable, 1);
        chk(cmd == NOP_C && sleep_ack, "R8 first exit NOP", cmd, NOP_C);
        for (int k = 1; k < NXE; k++) begin
            @(negedge clk);
            chk(cke && cmd == NOP_C && sleep_ack, "R8 exit NOP window", sleep_ack, 1);
        end
        @(negedge clk);
        chk(!sleep_ack && cke && cmd == NOP_C, "R8 ack falls", sleep_ack, 0);
        if (rearm) sleep_req = 1'b1;
        @(negedge clk);
        chk(cke && cmd == NOP_C && !sleep_ack, "R10 idle after ack", cmd, NOP_C);
        if (rearm) begin
            @(negedge clk);
            chk(cmd == PRE_C && pre_all, "R10 rearm precharge", cmd, PRE_C);
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cke && cmd == NOP_C && !pre_all && !sleep_ack, "R1 reset state", cmd, NOP_C);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cke && cmd == NOP_C && !sleep_ack, "R1 after release", cke, 1);

        // sweep wake cycle and clock-stable cycle (R5, R7)
        for (int w = 0; w < 8; w++) begin
            for (int s = 0; s < 8; s++) begin
                sleep_pass(w, s, 1'b0, 1'b0);
            end
        end
        // request withdrawn during precharge (R11)
        for (int s = 0; s < 8; s++) begin
            sleep_pass(0, s, 1'b1, 1'b0);
        end
        // long hold (R9)
        sleep_pass(40, 2, 1'b0, 1'b0);
        sleep_pass(3, 30, 1'b0, 1'b0);

        // immediate re-request after DONE (R10), then reset mid-sleep (R1)
        sleep_pass(1, 1, 1'b0, 1'b1);
        for (int k = 0; k < TRP + 2; k++) @(negedge clk);
        chk(!cke && sleep_ack, "R9 asleep before reset", cke, 0);
        rst_n = 1'b0;
        #1;
        chk(cke && cmd == NOP_C && !sleep_ack && !pre_all, "R1 async reset mid-sleep", cke, 1);
        sleep_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cke && cmd == NOP_C && !sleep_ack, "R1 idle after reset", cmd, NOP_C);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule